// File: doc/BRIEF.md
# Two-Level Correlated Branch Direction Predictor

This block forecasts whether a conditional branch will be taken. It keeps one global register of the most recent branch outcomes, and a table of 2-bit saturating counters. The table is arranged as rows that a hash of the branch address selects. Each row holds one counter for every possible value of the outcome register. Because the counters are split by the history value, branches that follow a repeating pattern can be predicted. Examples are a strict alternation, or two not-taken outcomes followed by two taken ones.

A fetch stage offers a branch address on a valid/ready lookup stream. One cycle later the block presents the forecast on a valid/ready response stream. The response also carries the history value that was used, so the pipeline can keep it as a snapshot. A new lookup is accepted only while the response slot is empty or being drained in the same cycle. A response that is not drained holds its data unchanged. When the branch resolves, the back end sends the branch address, the real outcome and that snapshot on the resolve pins. A resolve is always taken in the cycle its valid is high, with no back-pressure. It trains the counter that the snapshot names and shifts the outcome into the live history.

Top module: `bp2l_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history register is all zeros, so the first lookup of any address yields not taken with a history field of 0, and the response stream is empty.
- R2: The forecast is the upper bit of the selected counter: the codes 10 and 11 forecast taken, and the codes 00 and 01 forecast not taken.
- R3: A taken resolve raises the selected counter by one and a not-taken resolve lowers it by one. A counter at 11 stays at 11 when taken, and a counter at 00 stays at 00 when not taken.
- R4: The row index is the XOR of address bits [IDX_W+1:2] with address bits [2*IDX_W+1:IDX_W+2]. Two addresses with equal index share counters, and addresses with different index do not.
- R5: Inside a row the counter is picked by the history value, so a single branch repeating 0,0,1,1 is learned. After warm-up, history 001 forecasts taken, 011 not taken, 110 not taken and 100 taken.
- R6: Each resolve shifts its outcome into bit 0 of the history, and older bits move up. Without a resolve the history is unchanged.
- R7: A resolve trains the counter named by its own history snapshot and address, not by the live history value.
- R8: When a lookup and a resolve happen in the same cycle, the lookup sees the counter value and history value from before that resolve.
- R9: lk_ready is high exactly when no response is pending or pr_ready is high. An accepted lookup shows pr_valid in the next cycle, and a pending response with pr_ready low keeps pr_valid, pr_taken and pr_hist stable.
- R10: pr_hist equals the history register value in the cycle the lookup was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_pc | input | PC_W | Branch address to forecast |
| pr_valid | output | 1 | Forecast response present |
| pr_ready | input | 1 | Consumer takes the response |
| pr_taken | output | 1 | Forecast direction, 1 = taken |
| pr_hist | output | HIST_W | History value used by the forecast |
| rs_valid | input | 1 | Resolve present, always accepted |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_hist | input | HIST_W | History snapshot returned with the resolve |

## Verification
The lookup read and the resolve write can fall in the same cycle. They may even hit the same counter, and the resolve also moves the history that the lookup samples. The bench provokes this by driving a lookup and a resolve of the same address and snapshot on one edge. The response must carry the counter and history from before that edge. A behavioural model, updated after it has computed the forecast, judges the response. The lookup stream's back-pressure is also exercised while resolves keep arriving. The pending response must not move, and lk_ready must follow the response slot.

// File: rtl/bp2l_pkg.sv
package bp2l_pkg;
  typedef logic [1:0] sat2_t;

  localparam sat2_t CTR_SN = 2'b00;
  localparam sat2_t CTR_WN = 2'b01;
  localparam sat2_t CTR_WT = 2'b10;
  localparam sat2_t CTR_ST = 2'b11;

  // saturating up/down step of a direction counter
  function automatic sat2_t sat2_step(input sat2_t cur, input logic taken);
    sat2_t nxt;
    if (taken) nxt = (cur == CTR_ST) ? CTR_ST : cur + 2'd1;
    else       nxt = (cur == CTR_SN) ? CTR_SN : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/bp2l_hash.sv
module bp2l_hash #(
  parameter int IDX_W = 4
) (
  input  logic [2*IDX_W-1:0] pc_slice,
  output logic [IDX_W-1:0]   row
);
  // low half: address bits just above the word offset; high half: next group up
  assign row = pc_slice[IDX_W-1:0] ^ pc_slice[2*IDX_W-1:IDX_W];
endmodule

// File: rtl/bp2l_ghr.sv
module bp2l_ghr #(
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = shift_bit;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/bp2l_pht.sv
module bp2l_pht
  import bp2l_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_row,
  input  logic [HIST_W-1:0] rd_hist,
  output sat2_t             rd_ctr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [HIST_W-1:0] wr_hist,
  input  logic              wr_taken
);
  localparam int ADDR_W  = IDX_W + HIST_W;
  localparam int ENTRIES = 1 << ADDR_W;

  sat2_t             ctr_q [ENTRIES];
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;

  assign rd_addr = {rd_row, rd_hist};
  assign wr_addr = {wr_row, wr_hist};

  // read reflects state before this edge's write
  assign rd_ctr = ctr_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_WN;
    end else if (wr_en) begin
      ctr_q[wr_addr] <= sat2_step(ctr_q[wr_addr], wr_taken);
    end
  end
endmodule

// File: rtl/bp2l_predictor.sv
module bp2l_predictor
  import bp2l_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pr_valid,
  input  logic              pr_ready,
  output logic              pr_taken,
  output logic [HIST_W-1:0] pr_hist,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_taken,
  input  logic [HIST_W-1:0] rs_hist
);
  localparam int SLICE_LO = 2;
  localparam int SLICE_HI = SLICE_LO + 2*IDX_W - 1;

  logic [IDX_W-1:0]  lk_row;
  logic [IDX_W-1:0]  rs_row;
  logic [HIST_W-1:0] ghr_hist;
  sat2_t             lk_ctr;
  logic              lk_fire;

  logic              pr_valid_q;
  logic              pr_taken_q;
  logic [HIST_W-1:0] pr_hist_q;

  bp2l_hash #(.IDX_W(IDX_W)) u_hash_lk (
    .pc_slice (lk_pc[SLICE_HI:SLICE_LO]),
    .row      (lk_row)
  );

  bp2l_hash #(.IDX_W(IDX_W)) u_hash_rs (
    .pc_slice (rs_pc[SLICE_HI:SLICE_LO]),
    .row      (rs_row)
  );

  bp2l_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (rs_valid),
    .shift_bit (rs_taken),
    .hist      (ghr_hist)
  );

  bp2l_pht #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_row   (lk_row),
    .rd_hist  (ghr_hist),
    .rd_ctr   (lk_ctr),
    .wr_en    (rs_valid),
    .wr_row   (rs_row),
    .wr_hist  (rs_hist),
    .wr_taken (rs_taken)
  );

  assign lk_ready = !pr_valid_q || pr_ready;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid_q <= 1'b0;
      pr_taken_q <= 1'b0;
      pr_hist_q  <= '0;
    end else if (lk_fire) begin
      pr_valid_q <= 1'b1;
      pr_taken_q <= lk_ctr[1];
      pr_hist_q  <= ghr_hist;
    end else if (pr_ready) begin
      pr_valid_q <= 1'b0;
    end
  end

  assign pr_valid = pr_valid_q;
  assign pr_taken = pr_taken_q;
  assign pr_hist  = pr_hist_q;
endmodule

// File: rtl/bp2l_predictor_chk.sv
module bp2l_predictor_chk #(
  parameter int HIST_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              pr_valid,
  input logic              pr_ready,
  input logic              pr_taken,
  input logic [HIST_W-1:0] pr_hist,
  input logic              rs_valid,
  input logic              rs_taken,
  input logic [HIST_W-1:0] ghr_hist
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_empty_R1: assert (!pr_valid);
  end

  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_taken) && $stable(pr_hist));

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> pr_valid);

  assert_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> pr_hist == $past(ghr_hist));

  assert_newest_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> ghr_hist[0] == $past(rs_taken));

  assert_hist_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ghr_hist));
endmodule

bind bp2l_predictor bp2l_predictor_chk #(.HIST_W(HIST_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .pr_valid (pr_valid),
  .pr_ready (pr_ready),
  .pr_taken (pr_taken),
  .pr_hist  (pr_hist),
  .rs_valid (rs_valid),
  .rs_taken (rs_taken),
  .ghr_hist (ghr_hist)
);

// File: tb/bp2l_predictor_tb.sv
module bp2l_predictor_tb_top;
  localparam int PC_W = 32;
  localparam int K    = 4;
  localparam int H    = 3;
  localparam int NCTR = 1 << (K + H);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, pr_ready = 1'b1, rs_valid = 1'b0, rs_taken = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
  logic [H-1:0] rs_hist = '0;
  logic lk_ready, pr_valid, pr_taken;
  logic [H-1:0] pr_hist;

  always #5 clk = ~clk;

  bp2l_predictor #(.PC_W(PC_W), .IDX_W(K), .HIST_W(H)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken), .pr_hist(pr_hist),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_hist(rs_hist)
  );

  // behavioural reference state
  int mctr [NCTR];
  int m_hist;
  bit m_pv, m_pt;
  int m_ph;
  int nchk = 0, nfail = 0;

  function automatic int mrow(input logic [PC_W-1:0] pc);
    return ((pc >> 2) ^ (pc >> (K + 2))) & ((1 << K) - 1);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  // one cycle: drive at negedge, predict, clock, compare at next negedge
  task automatic step(input bit lkv, input logic [PC_W-1:0] lpc, input bit prr,
                      input bit rsv, input logic [PC_W-1:0] rpc, input bit rtk,
                      input int rh, input string tag);
    bit exp_rdy, n_pv, n_pt;
    int n_ph, ci;
    lk_valid = lkv; lk_pc = lpc; pr_ready = prr;
    rs_valid = rsv; rs_pc = rpc; rs_taken = rtk; rs_hist = rh[H-1:0];
    #1;
    exp_rdy = !m_pv || prr;
    check(lk_ready === exp_rdy, {tag, " R9 lk_ready"}, lk_ready, exp_rdy);
    n_pv = m_pv; n_pt = m_pt; n_ph = m_ph;
    if (lkv && exp_rdy) begin
      n_pv = 1; n_pt = (mctr[mrow(lpc) * (1 << H) + m_hist] >= 2); n_ph = m_hist;
    end else if (prr) n_pv = 0;
    if (rsv) begin
      ci = mrow(rpc) * (1 << H) + rh;
      if (rtk) mctr[ci] = (mctr[ci] == 3) ? 3 : mctr[ci] + 1;
      else     mctr[ci] = (mctr[ci] == 0) ? 0 : mctr[ci] - 1;
      m_hist = ((m_hist << 1) | int'(rtk)) & ((1 << H) - 1);
    end
    @(posedge clk); @(negedge clk);
    m_pv = n_pv; m_pt = n_pt; m_ph = n_ph;
    check(pr_valid === m_pv, {tag, " pr_valid"}, pr_valid, m_pv);
    if (m_pv) begin
      check(pr_taken === m_pt, {tag, " pr_taken"}, pr_taken, m_pt);
      check(int'(pr_hist) == m_ph, {tag, " R10 pr_hist"}, pr_hist, m_ph);
    end
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, input string tag);
    step(1, pc, 1, 0, '0, 0, 0, tag);
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input bit tk, input int h, input string tag);
    step(0, '0, 1, 1, pc, tk, h, tag);
  endtask

  task automatic do_reset();
    lk_valid = 0; pr_ready = 1; rs_valid = 0;
    rst_n = 0;
    for (int i = 0; i < NCTR; i++) mctr[i] = 1;
    m_hist = 0; m_pv = 0; m_pt = 0; m_ph = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pr_valid === 1'b0, "R1 reset pr_valid", pr_valid, 0);
    check(lk_ready === 1'b1, "R1 reset lk_ready", lk_ready, 1);
  endtask

  localparam logic [PC_W-1:0] PC_A  = 32'h0000_0040; // row 1
  localparam logic [PC_W-1:0] PC_AL = 32'h0000_0004; // row 1 (alias)
  localparam logic [PC_W-1:0] PC_N  = 32'h0000_0044; // row 0
  localparam logic [PC_W-1:0] PC_S  = 32'h0000_0100; // row 4
  localparam logic [PC_W-1:0] PC_X  = 32'h0000_0200; // row 8
  localparam logic [PC_W-1:0] PC_P  = 32'h0000_03C0; // row 15

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    bit held_t;
    int held_h;
    @(negedge clk);
    do_reset();

    // R1 / R2: fresh counter 01 forecasts not taken with history 0
    lookup(PC_A, "R1 first lookup");
    check(pr_taken === 1'b0 && pr_hist == 0, "R1 R2 fresh forecast", pr_taken, 0);

    // R4 / R7: train with snapshot 011 while live history is still 000
    resolve(PC_A, 1, 3, "R7 train1");
    resolve(PC_A, 1, 3, "R7 train2");          // live history now 011, counter 11
    lookup(PC_AL, "R4 alias");
    check(pr_taken === 1'b1, "R4 R7 alias shares trained counter", pr_taken, 1);
    lookup(PC_N, "R4 other row");
    check(pr_taken === 1'b0, "R4 distinct row untouched", pr_taken, 0);

    // R3: saturation at 00, then climb to 10
    do_reset();
    for (int i = 0; i < 4; i++) resolve(PC_S, 0, 0, "R3 down");
    lookup(PC_S, "R3 floor");
    check(pr_taken === 1'b0, "R3 floor forecast", pr_taken, 0);
    resolve(PC_S, 1, 0, "R3 up1");
    resolve(PC_S, 1, 0, "R3 up2");
    for (int i = 0; i < 3; i++) resolve(PC_X, 0, 0, "R6 clear hist");
    lookup(PC_S, "R3 after two ups");
    check(pr_taken === 1'b1, "R3 00 then two taken gives 10", pr_taken, 1);
    // saturation at 11: many takens, one not-taken stays taken
    for (int i = 0; i < 5; i++) resolve(PC_S, 1, 0, "R3 top");
    resolve(PC_S, 0, 0, "R3 one down");
    for (int i = 0; i < 3; i++) resolve(PC_X, 0, 0, "R6 clear hist");
    lookup(PC_S, "R3 ceiling");
    check(pr_taken === 1'b1, "R3 ceiling then one down stays taken", pr_taken, 1);

    // R8: lookup and resolve same counter in one cycle
    do_reset();
    step(1, PC_S, 1, 1, PC_S, 1, 0, "R8 same cycle");
    check(pr_taken === 1'b0 && pr_hist == 0, "R8 lookup sees old state", pr_taken, 0);
    resolve(PC_S, 1, 1, "R6 second outcome");
    lookup(PC_S, "R6 history 011");
    check(pr_hist == 3, "R6 history shifted newest into bit0", pr_hist, 3);

    // R9: back-pressure with resolves running underneath
    step(1, PC_A, 0, 0, '0, 0, 0, "R9 take while stalled");
    held_t = pr_taken; held_h = pr_hist;
    for (int i = 0; i < 3; i++) step(1, PC_S, 0, 1, PC_X, 1, 0, "R9 hold");
    check(pr_taken === held_t && pr_hist == held_h, "R9 held response stable", pr_hist, held_h);
    step(0, '0, 1, 0, '0, 0, 0, "R9 drain");
    check(pr_valid === 1'b0, "R9 drained", pr_valid, 0);

    // R5: learn 0011 repeating on one branch with global history
    do_reset();
    for (int k = 0; k < 32; k++) begin
      bit outc;
      int snap;
      outc = ((k % 4) >= 2);
      lookup(PC_P, "R5 pattern lookup");
      snap = pr_hist;
      if (k >= 12) check(pr_taken === outc, "R5 pattern forecast", pr_taken, outc);
      resolve(PC_P, outc, snap, "R5 pattern resolve");
    end

    finish_run();
  end
endmodule